// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Dispatcher

This block gathers fourteen single-cycle event pulses from power-management sources and records each in a sticky status bit. The bits are grouped into two byte-wide banks. A mask bit goes with every source. The block drives one active-low, level-sensitive summary interrupt. It stays low while any recorded event has its mask bit clear.

Software reaches the mask and status bytes through a simple strobe-based register port. A write of ones to a status byte clears those bits, and zeros in the write leave bits untouched.

A sequential dispatcher can take over the work of reading and clearing the status bytes. On a start pulse it visits bank 0 and then bank 1. For each bank it takes one snapshot, clears exactly the snapshot bits, and sends each recorded event as a flat source index on a valid/ready stream. The power-button pair in bank 0 has a fixed rule: when press (bit 7) and release (bit 6) are both in one snapshot, press goes out first and release second. The dispatcher raises a done flag once both banks are finished.

Top module: `evt_hub`

## Requirements
- R1: After reset every used mask bit is 1 and every status bit is 0. Bank 0 mask reads 0xFF and bank 1 mask reads 0x3F. `irq_n` is 1 and `disp_done` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k mod 8 of bank k div 8. This happens whether or not the source is masked.
- R3: A write to a status address clears each bit written as 1 and keeps each bit written as 0. An event that arrives in the same cycle as its own clear leaves the bit set.
- R4: `irq_n` is 0 exactly while some status bit is 1 and its mask bit is 0. A mask bit of 1 disables the source.
- R5: Mask bank 0 is at 0x0202 and mask bank 1 at 0x0203. Status bank 0 is at 0x0212 and status bank 1 at 0x0213. `reg_rdata` shows the addressed byte in the cycle after the `reg_rd` strobe. Bank 1 bits 7:6 always read 0.
- R6: A read of any other address returns 0, and a write to it changes no register.
- R7: A dispatch run sends bank 0 indices before bank 1 indices. Within a bank, indices go out in ascending bit order. Each index equals bit + 8 × bank.
- R8: If bank 0 bits 7 and 6 are both in the snapshot, index 7 goes out first, then index 6, then the other bank 0 bits in ascending order. Bit 6 alone follows the plain ascending order.
- R9: The dispatcher clears only the bits that were in its snapshot. An event that arrives after the snapshot stays set when the run ends.
- R10: One index goes out per cycle with `disp_valid` and `disp_ready` both high. The index is held stable while the stream is stalled. `disp_done` rises after both banks and stays high with `disp_valid` low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 14 | Single-cycle event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_n | output | 1 | Active-low summary interrupt |
| disp_start | input | 1 | Starts a dispatch run when not busy |
| disp_valid | output | 1 | Dispatched index is valid |
| disp_ready | input | 1 | Consumer accepts the index |
| disp_index | output | 4 | Flat source index |
| disp_done | output | 1 | Both banks processed |

## Verification
The latching path is driven three ways: events into masked sources, an event that collides with its own clear, and writes that mix ones and zeros. Together these separate sticky latching from masking and from write-one-to-clear. Dispatch runs use scattered bits across both banks, the press/release pair with a lower bit, and release on its own with a lower bit. These runs tell plain ascending order apart from the pair rule and bank-then-bit order apart from a flat scan. A run that is stalled while a fresh event lands after the snapshot shows that the index is held stable and that only snapshot bits are cleared.

// File: rtl/evt_hub_pkg.sv
package evt_hub_pkg;
  localparam int BANK_BITS = 8;
  localparam int BIT_W     = $clog2(BANK_BITS);

  typedef enum logic [1:0] {DS_IDLE, DS_SNAP, DS_EMIT, DS_DONE} disp_state_e;

  // lowest set bit of a bank byte (0 when none set)
  function automatic logic [BIT_W-1:0] lowest_set(input logic [BANK_BITS-1:0] v);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = BANK_BITS - 1; i >= 0; i--) begin
      if (v[i]) r = BIT_W'(i);
    end
    return r;
  endfunction

  // flat index of a bit within a bank
  function automatic int unsigned flat_index(input int unsigned bank, input int unsigned bitpos);
    return bank * BANK_BITS + bitpos;
  endfunction
endpackage

// File: rtl/evt_bank.sv
module evt_bank
  import evt_hub_pkg::*;
#(
  parameter int USED = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_BITS-1:0] evt,
  input  logic                 mask_we,
  input  logic                 stat_we,
  input  logic [BANK_BITS-1:0] wdata,
  input  logic [BANK_BITS-1:0] disp_clr,
  output logic [BANK_BITS-1:0] mask_q,
  output logic [BANK_BITS-1:0] stat_q,
  output logic                 pend
);
  for (genvar b = 0; b < BANK_BITS; b++) begin : g_bit
    if (b < USED) begin : g_used
      logic clr_b;
      assign clr_b = (stat_we & wdata[b]) | disp_clr[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q[b] <= 1'b1;
          stat_q[b] <= 1'b0;
        end else begin
          if (mask_we) mask_q[b] <= wdata[b];
          stat_q[b] <= (stat_q[b] & ~clr_b) | evt[b];
        end
      end
    end else begin : g_unused
      assign mask_q[b] = 1'b0;
      assign stat_q[b] = 1'b0;
    end
  end

  assign pend = |(stat_q & ~mask_q);
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
  import evt_hub_pkg::*;
#(
  parameter int NB        = 2,
  parameter int PRESS_BIT = 7,
  parameter int REL_BIT   = 6,
  localparam int TOT_W    = NB * BANK_BITS,
  localparam int IDX_W    = $clog2(TOT_W),
  localparam int BANK_W   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TOT_W-1:0] stat_all,
  output logic [TOT_W-1:0] clr_all,
  output logic             valid,
  input  logic             ready,
  output logic [IDX_W-1:0] index,
  output logic             done
);
  disp_state_e          state_q;
  logic [BANK_W-1:0]    bank_q;
  logic [BANK_BITS-1:0] snap_q;
  logic                 pair_q;
  logic [BANK_BITS-1:0] cur;
  logic [BIT_W-1:0]     pick;
  logic                 first_bank;

  assign cur        = stat_all[bank_q*BANK_BITS +: BANK_BITS];
  assign first_bank = (bank_q == '0);

  always_comb begin
    if (first_bank && snap_q[PRESS_BIT] && snap_q[REL_BIT])
      pick = BIT_W'(PRESS_BIT);
    else if (first_bank && pair_q && snap_q[REL_BIT])
      pick = BIT_W'(REL_BIT);
    else
      pick = lowest_set(snap_q);
  end

  always_comb begin
    clr_all = '0;
    if (state_q == DS_SNAP) clr_all[bank_q*BANK_BITS +: BANK_BITS] = cur;
  end

  assign valid = (state_q == DS_EMIT) && (snap_q != '0);
  assign index = IDX_W'(flat_index(int'(bank_q), int'(pick)));
  assign done  = (state_q == DS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      bank_q  <= '0;
      snap_q  <= '0;
      pair_q  <= 1'b0;
    end else begin
      case (state_q)
        DS_IDLE, DS_DONE: if (start) begin
          state_q <= DS_SNAP;
          bank_q  <= '0;
        end
        DS_SNAP: begin
          snap_q  <= cur;
          pair_q  <= first_bank & cur[PRESS_BIT] & cur[REL_BIT];
          state_q <= DS_EMIT;
        end
        DS_EMIT: begin
          if (snap_q == '0) begin
            if (bank_q == BANK_W'(NB - 1)) state_q <= DS_DONE;
            else begin
              bank_q  <= bank_q + 1'b1;
              state_q <= DS_SNAP;
            end
          end else if (ready) begin
            snap_q[pick] <= 1'b0;
          end
        end
        default: state_q <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_hub.sv
module evt_hub
  import evt_hub_pkg::*;
#(
  parameter int          NUM_SRC   = 14,
  parameter logic [15:0] MASK_ADDR = 16'h0202,
  parameter logic [15:0] STAT_ADDR = 16'h0212,
  localparam int NB    = (NUM_SRC + BANK_BITS - 1) / BANK_BITS,
  localparam int TOT_W = NB * BANK_BITS,
  localparam int IDX_W = $clog2(TOT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [15:0]        reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_n,
  input  logic               disp_start,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [IDX_W-1:0]   disp_index,
  output logic               disp_done
);
  logic [TOT_W-1:0] evt_pad;
  logic [TOT_W-1:0] mask_all;
  logic [TOT_W-1:0] stat_all;
  logic [TOT_W-1:0] clr_all;
  logic [NB-1:0]    pend;
  logic [NB-1:0]    hit_mask;
  logic [NB-1:0]    hit_stat;
  logic [7:0]       rd_sel;

  always_comb begin
    evt_pad = '0;
    evt_pad[NUM_SRC-1:0] = evt_i;
  end

  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam int USED_K = (NUM_SRC - k * BANK_BITS >= BANK_BITS) ? BANK_BITS
                                                                   : NUM_SRC - k * BANK_BITS;
    assign hit_mask[k] = (reg_addr == 16'(MASK_ADDR + k));
    assign hit_stat[k] = (reg_addr == 16'(STAT_ADDR + k));

    evt_bank #(.USED(USED_K)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_pad[k*BANK_BITS +: BANK_BITS]),
      .mask_we  (reg_wr & hit_mask[k]),
      .stat_we  (reg_wr & hit_stat[k]),
      .wdata    (reg_wdata),
      .disp_clr (clr_all[k*BANK_BITS +: BANK_BITS]),
      .mask_q   (mask_all[k*BANK_BITS +: BANK_BITS]),
      .stat_q   (stat_all[k*BANK_BITS +: BANK_BITS]),
      .pend     (pend[k])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NB; k++) begin
      if (hit_mask[k]) rd_sel = mask_all[k*BANK_BITS +: BANK_BITS];
      if (hit_stat[k]) rd_sel = stat_all[k*BANK_BITS +: BANK_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_sel;
  end

  assign irq_n = ~|pend;

  evt_dispatch #(.NB(NB)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (disp_start),
    .stat_all (stat_all),
    .clr_all  (clr_all),
    .valid    (disp_valid),
    .ready    (disp_ready),
    .index    (disp_index),
    .done     (disp_done)
  );
endmodule

// File: rtl/evt_hub_chk.sv
module evt_hub_chk #(
  parameter int NUM_SRC = 14,
  parameter int TOT_W   = 16,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TOT_W-1:0] evt_pad,
  input logic [TOT_W-1:0] stat_all,
  input logic [TOT_W-1:0] mask_all,
  input logic             irq_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [IDX_W-1:0] disp_index,
  input logic             disp_done
);
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pad != '0) |=> ((stat_all & $past(evt_pad)) == $past(evt_pad)));

  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((stat_all & ~mask_all) == '0));

  p_index_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_index) < NUM_SRC));

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_index)));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_done |-> !disp_valid);
endmodule

bind evt_hub evt_hub_chk #(.NUM_SRC(NUM_SRC), .TOT_W(TOT_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_pad    (evt_pad),
  .stat_all   (stat_all),
  .mask_all   (mask_all),
  .irq_n      (irq_n),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_index (disp_index),
  .disp_done  (disp_done)
);

// File: tb/evt_hub_tb_top.sv
`timescale 1ns/1ps
module evt_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt_i = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n;
  logic        disp_start = 1'b0, disp_valid, disp_ready = 1'b0, disp_done;
  logic [3:0]  disp_index;

  int nchk = 0, nfail = 0;
  bit ended = 0;
  int got[$];

  always #5 clk = ~clk;

  evt_hub dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
    .disp_start(disp_start), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_index(disp_index), .disp_done(disp_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [13:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic start_run();
    @(negedge clk); disp_start = 1'b1;
    @(negedge clk); disp_start = 1'b0;
  endtask

  task automatic collect();
    disp_ready = 1'b1;
    for (int c = 0; c < 200; c++) begin
      if (disp_valid) got.push_back(int'(disp_index));
      if (disp_done) break;
      @(negedge clk);
    end
    disp_ready = 1'b0;
  endtask

  task automatic check_seq(input string req, input int exp[$]);
    chk({req, " count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      chk({req, " order"}, got[i], exp[i]);
    chk({req, " done"}, int'(disp_done), 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 done", int'(disp_done), 0);
    rd(16'h0202, d); chk("R1 mask0", d, 8'hFF);
    rd(16'h0203, d); chk("R1 mask1", d, 8'h3F);
    rd(16'h0212, d); chk("R1 stat0", d, 0);
    rd(16'h0213, d); chk("R1 stat1", d, 0);
  endtask

  task automatic t_latch_masked();
    logic [7:0] d;
    pulse(14'h0208);
    rd(16'h0212, d); chk("R2 stat0", d, 8'h08);
    rd(16'h0213, d); chk("R2 stat1", d, 8'h02);
    chk("R4 masked irq_n", int'(irq_n), 1);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(16'h0202, 8'hF7);
    chk("R4 unmasked irq_n", int'(irq_n), 0);
    rd(16'h0202, d); chk("R5 mask0 rd", d, 8'hF7);
    wr(16'h0203, 8'h00); wr(16'h0203, 8'hFF);
    rd(16'h0203, d); chk("R5 mask1 unused", d, 8'h3F);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(16'h0212, 8'h00);
    rd(16'h0212, d); chk("R3 write0 keeps", d, 8'h08);
    wr(16'h0212, 8'h08);
    rd(16'h0212, d); chk("R3 write1 clears", d, 8'h00);
    chk("R4 cleared irq_n", int'(irq_n), 1);
    wr(16'h0213, 8'hFD);
    rd(16'h0213, d); chk("R3 other bits kept", d, 8'h02);
    wr(16'h0213, 8'h02);
    rd(16'h0213, d); chk("R3 stat1 clear", d, 8'h00);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 16'h0212; reg_wdata = 8'h20; evt_i = 14'h0020;
    @(negedge clk); reg_wr = 1'b0; evt_i = '0;
    rd(16'h0212, d); chk("R3 event beats clear", d, 8'h20);
    wr(16'h0212, 8'hFF);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(16'h0204, 8'h00);
    wr(16'h0214, 8'hFF);
    rd(16'h0204, d); chk("R6 unmapped rd", d, 0);
    rd(16'h0000, d); chk("R6 addr 0 rd", d, 0);
    rd(16'h0202, d); chk("R6 mask0 untouched", d, 8'hF7);
    rd(16'h0203, d); chk("R6 mask1 untouched", d, 8'h3F);
  endtask

  task automatic t_order();
    logic [7:0] d;
    pulse(14'h2113);
    got.delete(); start_run(); collect();
    check_seq("R7", '{0, 1, 4, 8, 13});
    rd(16'h0212, d); chk("R9 stat0 cleared", d, 0);
    rd(16'h0213, d); chk("R9 stat1 cleared", d, 0);
  endtask

  task automatic t_pair();
    pulse(14'h04C4);
    got.delete(); start_run(); collect();
    check_seq("R8 pair", '{7, 6, 2, 10});
    pulse(14'h0048);
    got.delete(); start_run(); collect();
    check_seq("R8 release alone", '{3, 6});
  endtask

  task automatic t_stall();
    logic [7:0] d;
    int idx0;
    pulse(14'h0804);
    got.delete(); start_run();
    for (int c = 0; c < 20 && !disp_valid; c++) @(negedge clk);
    chk("R10 valid", int'(disp_valid), 1);
    idx0 = int'(disp_index);
    chk("R10 first index", idx0, 2);
    pulse(14'h0004);
    for (int c = 0; c < 3; c++) begin
      chk("R10 stalled valid", int'(disp_valid), 1);
      chk("R10 stalled index", int'(disp_index), idx0);
      @(negedge clk);
    end
    collect();
    check_seq("R10 after stall", '{2, 11});
    chk("R10 quiet when done", int'(disp_valid), 0);
    rd(16'h0212, d); chk("R9 late event kept", d, 8'h04);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_masked();
    t_mask();
    t_w1c();
    t_unmapped();
    t_order();
    t_pair();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule